// File: doc/BRIEF.md
# Paged 4K-Word Window Memory

This block is a memory that answers one 4K-word window of a 16-bit word address space. Behind that window sit up to sixteen pages of 4K words, numbered with a 4-bit page number. One page is selected at a time, and only the selected page responds to bus reads and writes. A parameter gives the window base, which must be 4K-aligned. A contiguous run of page numbers, set by two parameters, is backed by storage. A selected page number outside that run behaves as empty and reads as all ones.

The selected page changes only through a keyed bus write to the last word of the window (offset 0xFFF). The write data must be the window's own top address nibble in bits 15:12, the constant 0xA5 in bits 11:4, and the new page number in bits 3:0. Any other write, including one to offset 0xFFF with the wrong key, is an ordinary data write. In ROM mode an ordinary data write is dropped. In RAM mode it stores the low DATA_W bits into the selected page. A separate debug poke port writes the selected page directly. This port is used to load ROM contents or patch RAM, and it never looks for the key.

Read data is registered, so it appears one clock after the read strobe. A new page selection applies from the access in the following clock onward.

Top module: `paged_window_mem`

## Requirements
- R1: While rst is high at a clock edge, the selected page becomes 0 and rd_data in the next cycle is 16'hFFFF.
- R2: A bus write with addr == {BASE_ADDR[15:12], 12'hFFF} and wr_data[15:4] == {BASE_ADDR[15:12], 8'hA5} loads wr_data[3:0] as the selected page. The new page serves accesses from the next clock on, and a read in the same cycle still sees the old page.
- R3: A write whose top nibble, key bits 11:4 or offset differ from R2, or whose addr[15:12] is outside the window, leaves the selected page unchanged.
- R4: A read with rd_en high and addr[15:12] == BASE_ADDR[15:12] gives, in the next cycle, the stored word of the selected page at offset addr[11:0], zero-extended from DATA_W bits to 16 bits.
- R5: rd_data is 16'hFFFF in the cycle after a cycle with rd_en low, with an address outside the window, or with a selected page outside LO_PAGE to LO_PAGE+N_PAGES-1.
- R6: With IS_RAM = 0, bus writes never change the stored contents.
- R7: With IS_RAM = 1, a non-key bus write in the window stores wr_data[DATA_W-1:0] at addr[11:0] of the selected page. A key write (R2) stores nothing, and each page keeps its own contents.
- R8: With poke_en high, poke_data[DATA_W-1:0] is stored at poke_off of the selected page, in either mode. The selected page is not changed even if the data matches the key, and a poke to an unbacked page is dropped.
- R9: When poke_en and a RAM data write coincide, only the poke is stored and the bus data write is lost.
- R10: A read and a data write to the same word in the same cycle return the old word, and the new word appears on the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Bus word address |
| wr_data | input | 16 | Bus write data |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| rd_data | output | 16 | Read data, one clock after rd_en |
| poke_en | input | 1 | Debug poke strobe |
| poke_off | input | 12 | Debug poke word offset |
| poke_data | input | 16 | Debug poke data |

## Verification
The hardest case to reach from the ports is a write to offset 0xFFF that almost carries the key. These near misses must land as plain RAM data, while the selected page stays where it was. The stimulus sends writes to 0xFFF with a wrong top nibble, a wrong key byte, the right key at offset 0xFFE, and the right key from outside the window. It then reads back both the stored word and a word known only on the old page. It also overlaps a key write with a read, a poke with a bus write, and a read with a write to the same word. It selects an unbacked page and pokes into it. The behavioural model in the bench predicts every cycle of these sequences.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ADDR_W = 16;
  localparam int OFF_W  = 12;
  localparam int PAGE_W = 4;
  localparam logic [7:0] KEY_MID = 8'hA5;

  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [OFF_W-1:0]  off_t;

  function automatic logic page_backed(page_t p, int lo, int n);
    return (int'(p) >= lo) && (int'(p) < lo + n);
  endfunction
endpackage

// File: rtl/pwm_page_ctl.sv
module pwm_page_ctl
  import pwm_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wr_data,
  output logic              win_hit,
  output logic              key_hit,
  output page_t             page_q
);
  localparam logic [3:0] WIN_NIB = BASE_ADDR[15:12];
  localparam off_t       LAST_OFF = '1;

  always_comb begin
    win_hit = (addr[ADDR_W-1:OFF_W] == WIN_NIB);
    key_hit = win_hit && (addr[OFF_W-1:0] == LAST_OFF)
              && (wr_data[15:4] == {WIN_NIB, KEY_MID});
  end

  always_ff @(posedge clk) begin
    if (rst)
      page_q <= '0;
    else if (wr_en && key_hit)
      page_q <= wr_data[PAGE_W-1:0];
  end
endmodule

// File: rtl/pwm_page_store.sv
module pwm_page_store
  import pwm_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int LO_PAGE = 0,
  parameter int N_PAGES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  page_t             page,
  input  logic              we,
  input  off_t              w_off,
  input  logic [DATA_W-1:0] w_data,
  input  logic              re,
  input  off_t              r_off,
  output logic [15:0]       rd_word
);
  localparam int SLOT_W = (N_PAGES > 1) ? $clog2(N_PAGES) : 1;
  localparam int IDX_W  = SLOT_W + OFF_W;
  localparam int DEPTH  = N_PAGES << OFF_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic              rd_ok;
  logic              backed;
  logic [SLOT_W-1:0] slot;
  logic [IDX_W-1:0]  w_idx, r_idx;

  always_comb begin
    backed = page_backed(page, LO_PAGE, N_PAGES);
    slot   = SLOT_W'(int'(page) - LO_PAGE);
    w_idx  = {slot, w_off};
    r_idx  = {slot, r_off};
  end

  // single write port, read-first: block RAM friendly
  always_ff @(posedge clk) begin
    if (we && backed)
      mem[w_idx] <= w_data;
    if (re && backed)
      rd_q <= mem[r_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_ok <= 1'b0;
    else     rd_ok <= re && backed;
  end

  assign rd_word = rd_ok ? 16'(rd_q) : 16'hFFFF;
endmodule

// File: rtl/paged_window_mem.sv
module paged_window_mem
  import pwm_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h5000,
  parameter int          DATA_W    = 16,
  parameter bit          IS_RAM    = 1'b1,
  parameter int          LO_PAGE   = 0,
  parameter int          N_PAGES   = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] addr,
  input  logic [15:0] wr_data,
  input  logic        wr_en,
  input  logic        rd_en,
  output logic [15:0] rd_data,
  input  logic        poke_en,
  input  logic [11:0] poke_off,
  input  logic [15:0] poke_data
);
  logic              win_hit, key_hit;
  page_t             page_sel;
  logic              bus_store, st_we;
  off_t              st_off;
  logic [DATA_W-1:0] st_data;

  pwm_page_ctl #(.BASE_ADDR(BASE_ADDR)) u_ctl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .win_hit(win_hit), .key_hit(key_hit), .page_q(page_sel)
  );

  always_comb begin
    bus_store = IS_RAM && wr_en && win_hit && !key_hit;
    st_we     = poke_en || bus_store;
    if (poke_en) begin
      st_off  = poke_off;
      st_data = poke_data[DATA_W-1:0];
    end else begin
      st_off  = addr[OFF_W-1:0];
      st_data = wr_data[DATA_W-1:0];
    end
  end

  pwm_page_store #(.DATA_W(DATA_W), .LO_PAGE(LO_PAGE), .N_PAGES(N_PAGES)) u_store (
    .clk(clk), .rst(rst), .page(page_sel),
    .we(st_we), .w_off(st_off), .w_data(st_data),
    .re(rd_en && win_hit), .r_off(addr[OFF_W-1:0]),
    .rd_word(rd_data)
  );
endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
  parameter logic [15:0] BASE_ADDR = 16'h5000,
  parameter int          DATA_W    = 16
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] addr,
  input logic [15:0] wr_data,
  input logic        wr_en,
  input logic        rd_en,
  input logic [15:0] rd_data,
  input logic [3:0]  page_sel
);
  logic key_wr;
  assign key_wr = wr_en && (addr == {BASE_ADDR[15:12], 12'hFFF})
                  && (wr_data[15:4] == {BASE_ADDR[15:12], 8'hA5});

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (page_sel == 4'd0) && (rd_data == 16'hFFFF));

  p_sel_load_r2: assert property (@(posedge clk) disable iff (rst)
    key_wr |=> page_sel == $past(wr_data[3:0]));

  p_sel_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !key_wr |=> $stable(page_sel));

  p_width_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_data == 16'hFFFF) || ((32'(rd_data) >> DATA_W) == 0));

  p_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rd_data == 16'hFFFF);

  p_miss_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[15:12] != BASE_ADDR[15:12]) |=> rd_data == 16'hFFFF);
endmodule

bind paged_window_mem pwm_checker #(.BASE_ADDR(BASE_ADDR), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
  .rd_en(rd_en), .rd_data(rd_data), .page_sel(page_sel)
);

// File: tb/paged_window_mem_test.sv
`timescale 1ns/1ps
module paged_window_mem_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [15:0] a_addr[2], a_wd[2], a_pd[2], a_rd[2];
  logic        a_we[2], a_re[2], a_pe[2];
  logic [11:0] a_po[2];

  // instance 0: RAM, base 0x5000, 12-bit words, pages 1..2
  paged_window_mem #(.BASE_ADDR(16'h5000), .DATA_W(12), .IS_RAM(1'b1),
                     .LO_PAGE(1), .N_PAGES(2)) uut (
    .clk(clk), .rst(rst), .addr(a_addr[0]), .wr_data(a_wd[0]), .wr_en(a_we[0]),
    .rd_en(a_re[0]), .rd_data(a_rd[0]), .poke_en(a_pe[0]),
    .poke_off(a_po[0]), .poke_data(a_pd[0]));

  // instance 1: ROM, base 0x2000, 16-bit words, page 0 only
  paged_window_mem #(.BASE_ADDR(16'h2000), .DATA_W(16), .IS_RAM(1'b0),
                     .LO_PAGE(0), .N_PAGES(1)) rom_uut (
    .clk(clk), .rst(rst), .addr(a_addr[1]), .wr_data(a_wd[1]), .wr_en(a_we[1]),
    .rd_en(a_re[1]), .rd_data(a_rd[1]), .poke_en(a_pe[1]),
    .poke_off(a_po[1]), .poke_data(a_pd[1]));

  // reference model
  int          m_nib[2]  = '{5, 2};
  int          m_lo[2]   = '{1, 0};
  int          m_n[2]    = '{2, 1};
  bit          m_ram[2]  = '{1'b1, 1'b0};
  logic [15:0] m_mask[2] = '{16'h0FFF, 16'hFFFF};
  int          m_sel[2];
  logic [15:0] m_mem[int];

  int total = 0, bad = 0;
  bit done = 0;

  function automatic bit backed(int i, int p);
    return p >= m_lo[i] && p < m_lo[i] + m_n[i];
  endfunction

  task automatic check(string tag, int i, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s inst%0d rd_data=%h expected=%h", tag, i, act, exp);
    end
  endtask

  task automatic idle_inputs();
    for (int j = 0; j < 2; j++) begin
      a_addr[j] = 16'h0; a_wd[j] = 16'h0; a_pd[j] = 16'h0; a_po[j] = 12'h0;
      a_we[j] = 1'b0; a_re[j] = 1'b0; a_pe[j] = 1'b0;
    end
  endtask

  // one clock of stimulus on instance i; both outputs compared next cycle
  task automatic op(int i, bit re, bit we, logic [15:0] ad, logic [15:0] wd,
                    bit pe, logic [11:0] po, logic [15:0] pd, string tag);
    logic [15:0] exp[2];
    bit          known[2];
    int          off, key;
    bit          in_win;
    idle_inputs();
    a_addr[i] = ad; a_wd[i] = wd; a_we[i] = we; a_re[i] = re;
    a_pe[i] = pe; a_po[i] = po; a_pd[i] = pd;
    for (int j = 0; j < 2; j++) begin exp[j] = 16'hFFFF; known[j] = 1; end
    in_win = (int'(ad[15:12]) == m_nib[i]);
    off = int'(ad[11:0]);
    if (re && in_win && backed(i, m_sel[i])) begin
      key = i * 65536 + m_sel[i] * 4096 + off;
      if (m_mem.exists(key)) exp[i] = m_mem[key];
      else known[i] = 0;
    end
    if (pe && backed(i, m_sel[i]))
      m_mem[i * 65536 + m_sel[i] * 4096 + int'(po)] = pd & m_mask[i];
    if (we && in_win) begin
      if (off == 12'hFFF && int'(wd[15:12]) == m_nib[i] && wd[11:4] == 8'hA5)
        m_sel[i] = int'(wd[3:0]);
      else if (m_ram[i] && !pe && backed(i, m_sel[i]))
        m_mem[i * 65536 + m_sel[i] * 4096 + off] = wd & m_mask[i];
    end
    @(posedge clk);
    @(negedge clk);
    for (int j = 0; j < 2; j++)
      if (known[j]) check(tag, j, a_rd[j], exp[j]);
  endtask

  task automatic do_reset();
    idle_inputs();
    rst = 1'b1;
    m_sel[0] = 0; m_sel[1] = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", 0, a_rd[0], 16'hFFFF);
    check("R1", 1, a_rd[1], 16'hFFFF);
    rst = 1'b0;
  endtask

  task automatic rd(int i, logic [15:0] ad, string tag);
    op(i, 1, 0, ad, 16'h0, 0, 12'h0, 16'h0, tag);
  endtask
  task automatic wr(int i, logic [15:0] ad, logic [15:0] wd, string tag);
    op(i, 0, 1, ad, wd, 0, 12'h0, 16'h0, tag);
  endtask
  task automatic pk(int i, logic [11:0] po, logic [15:0] pd, string tag);
    op(i, 0, 0, 16'h0, 16'h0, 1, po, pd, tag);
  endtask

  initial begin
    idle_inputs();
    @(negedge clk);
    do_reset();
    // R1/R5: page 0 is unbacked on the RAM instance
    rd(0, 16'h5000, "R1");
    wr(0, 16'h5010, 16'h1234, "R5");
    // R2: select page 1, read right after
    wr(0, 16'h5FFF, 16'h5A51, "R2");
    wr(0, 16'h5010, 16'hABCD, "R7");
    rd(0, 16'h5010, "R4");
    wr(0, 16'h5040, 16'h0555, "R7");
    // R3: near-miss keys store as data, page unchanged
    wr(0, 16'h5FFF, 16'h6A52, "R3");
    rd(0, 16'h5FFF, "R3");
    wr(0, 16'h5FFF, 16'h5A42, "R3");
    wr(0, 16'h5FFE, 16'h5A52, "R3");
    rd(0, 16'h5FFE, "R3");
    wr(0, 16'h6FFF, 16'h5A52, "R3");
    rd(0, 16'h5010, "R3");
    // R2: read in the select cycle sees old page
    op(0, 1, 1, 16'h5FFF, 16'h5A52, 0, 12'h0, 16'h0, "R2");
    wr(0, 16'h5FFF, 16'h0777, "R7");
    wr(0, 16'h5010, 16'h0111, "R7");
    rd(0, 16'h5010, "R7");
    // R10: read-first
    op(0, 1, 1, 16'h5010, 16'h0222, 0, 12'h0, 16'h0, "R10");
    rd(0, 16'h5010, "R10");
    // R7: back to page 1, contents kept, key write did not store
    wr(0, 16'h5FFF, 16'h5A51, "R2");
    rd(0, 16'h5010, "R7");
    rd(0, 16'h5FFF, "R7");
    // R5: unbacked page 3
    wr(0, 16'h5FFF, 16'h5A53, "R2");
    rd(0, 16'h5010, "R5");
    wr(0, 16'h5010, 16'h0999, "R5");
    pk(0, 12'h010, 16'h0888, "R8");
    wr(0, 16'h5FFF, 16'h5A51, "R2");
    rd(0, 16'h5010, "R8");
    // R8: poke, including key-like data
    pk(0, 12'h020, 16'hF999, "R8");
    rd(0, 16'h5020, "R8");
    pk(0, 12'hFFF, 16'h5A52, "R8");
    rd(0, 16'h5FFF, "R8");
    rd(0, 16'h5010, "R8");
    // R9: poke beats bus write
    op(0, 0, 1, 16'h5040, 16'h0444, 1, 12'h030, 16'h0333, "R9");
    rd(0, 16'h5040, "R9");
    rd(0, 16'h5030, "R9");
    // R5: outside window, no strobe
    rd(0, 16'h4010, "R5");
    op(0, 0, 0, 16'h5010, 16'h0, 0, 12'h0, 16'h0, "R5");
    // ROM instance
    pk(1, 12'h100, 16'hBEEF, "R8");
    rd(1, 16'h2100, "R8");
    wr(1, 16'h2100, 16'h1111, "R6");
    rd(1, 16'h2100, "R6");
    pk(1, 12'hFFF, 16'hCAFE, "R8");
    wr(1, 16'h2FFF, 16'h1234, "R6");
    rd(1, 16'h2FFF, "R6");
    wr(1, 16'h2FFF, 16'h2A51, "R2");
    rd(1, 16'h2100, "R5");
    wr(1, 16'h2FFF, 16'h2A50, "R2");
    rd(1, 16'h2100, "R2");
    // R1: reset mid-run
    wr(0, 16'h5FFF, 16'h5A52, "R2");
    do_reset();
    rd(0, 16'h5010, "R1");
    rd(1, 16'h2100, "R1");
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule